// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is the sequencing core of a single-slot vending machine that sells one item priced at 20 cents. Each clock cycle it may receive a one-cycle pulse that marks an accepted 5-cent coin or an accepted 10-cent coin. It keeps the credit gathered so far in a small binary-coded register. The credit is counted in steps of 5 cents, so the register holds one of four values: 0, 5, 10 or 15 cents, encoded as 2'b00, 2'b01, 2'b10 and 2'b11.

The outputs are Mealy outputs. When a coin completes the price, the vend strobe rises in the same cycle as that coin pulse. If the coin pushes the total one nickel past the price, a change strobe rises with it and returns one 5-cent coin. After a sale the credit goes back to zero on the next clock edge. If both coin pulses arrive in the same cycle, the controller treats the cycle as invalid: it produces no strobe and leaves the credit unchanged.

The price in nickel units is a parameter, and its default is 4 (20 cents).

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high, both strobes are 0. After a clock edge with `rst` high, the credit is 0 cents (code 2'b00).
- R2: A lone `nickel_i` pulse at a credit of 0, 5 or 10 cents raises the credit by 5 cents and keeps both strobes at 0.
- R3: A lone `dime_i` pulse at a credit of 0 or 5 cents raises the credit by 10 cents and keeps both strobes at 0.
- R4: A lone `nickel_i` pulse at 15 cents drives `vend_o`=1 and `change_o`=0, and the credit becomes 0.
- R5: A lone `dime_i` pulse at 10 cents drives `vend_o`=1 and `change_o`=0, and the credit becomes 0.
- R6: A lone `dime_i` pulse at 15 cents drives `vend_o`=1 and `change_o`=1, and the credit becomes 0.
- R7: In a cycle with no coin pulse, both strobes are 0 and the credit is held.
- R8: In a cycle where `nickel_i` and `dime_i` are both high, both strobes are 0 and the credit is held.
- R9: The strobes are valid in the same cycle as the coin pulse that causes them, not one cycle later.
- R10: `change_o` is never 1 unless `vend_o` is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| vend_o | output | 1 | Release one item (Mealy output) |
| change_o | output | 1 | Return one 5-cent coin (Mealy output) |

## Verification
Two functions can land in the same cycle: the sale and the return of change. A 10-cent coin arriving at 15 cents must raise both strobes in that coin's own cycle. The bench builds up 15 cents with a nickel followed by a dime, then sends the dime. It samples both strobes after the inputs have settled and before the next clock edge. It then confirms that the credit went back to zero by showing that two more dimes are needed for the next sale. A sale without change, and a clash cycle at 15 cents that is followed by a nickel, separate the overshoot case from its neighbouring cases.

// File: rtl/vend_pkg.sv
package vend_pkg;
    // Classification of the coin pulses seen in one cycle
    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10,
        COIN_CLASH  = 2'b11
    } coin_kind_e;

    // Coin values in nickel units
    localparam int unsigned NICKEL_UNITS = 1;
    localparam int unsigned DIME_UNITS   = 2;
    localparam int unsigned UNIT_W       = 2;
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic               nickel_i,
    input  logic               dime_i,
    output coin_kind_e         kind_o,
    output logic [UNIT_W-1:0]  units_o
);
    always_comb begin
        kind_o  = coin_kind_e'({dime_i, nickel_i});
        units_o = '0;
        unique case (kind_o)
            COIN_NICKEL: units_o = UNIT_W'(NICKEL_UNITS);
            COIN_DIME:   units_o = UNIT_W'(DIME_UNITS);
            default:     units_o = '0;  // none, or both at once: no credit
        endcase
    end
endmodule

// File: rtl/vend_credit_step.sv
module vend_credit_step
    import vend_pkg::*;
#(
    parameter int unsigned PRICE_UNITS = 4,
    localparam int unsigned CRED_W = $clog2(PRICE_UNITS),
    localparam int unsigned SUM_W  = CRED_W + UNIT_W
) (
    input  logic [CRED_W-1:0] credit_i,
    input  logic [UNIT_W-1:0] units_i,
    output logic [CRED_W-1:0] credit_o,
    output logic              vend_o,
    output logic              change_o
);
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum      = SUM_W'(credit_i) + SUM_W'(units_i);
        vend_o   = 1'b0;
        change_o = 1'b0;
        credit_o = credit_i;
        if (sum >= SUM_W'(PRICE_UNITS)) begin
            vend_o   = 1'b1;
            change_o = (sum > SUM_W'(PRICE_UNITS));
            credit_o = '0;
        end else begin
            credit_o = CRED_W'(sum);
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int unsigned PRICE_UNITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic vend_o,
    output logic change_o
);
    localparam int unsigned CRED_W = $clog2(PRICE_UNITS);

    typedef struct packed {
        logic [CRED_W-1:0] credit;
    } state_t;

    state_t             state_d, state_q;
    coin_kind_e         coin_kind;
    logic [UNIT_W-1:0]  coin_units;
    logic [CRED_W-1:0]  step_credit;
    logic               step_vend, step_change;
    logic [CRED_W-1:0]  credit_q;

    vend_coin_decode u_decode (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .kind_o   (coin_kind),
        .units_o  (coin_units)
    );

    vend_credit_step #(.PRICE_UNITS(PRICE_UNITS)) u_step (
        .credit_i (state_q.credit),
        .units_i  (coin_units),
        .credit_o (step_credit),
        .vend_o   (step_vend),
        .change_o (step_change)
    );

    always_comb begin
        state_d  = state_q;
        vend_o   = 1'b0;
        change_o = 1'b0;
        if (rst) begin
            state_d.credit = '0;
        end else if (coin_kind == COIN_NICKEL || coin_kind == COIN_DIME) begin
            state_d.credit = step_credit;
            vend_o         = step_vend;
            change_o       = step_change;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign credit_q = state_q.credit;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int unsigned PRICE_UNITS = 4,
    localparam int unsigned CRED_W = $clog2(PRICE_UNITS)
) (
    input logic              clk,
    input logic              rst,
    input logic              nickel_i,
    input logic              dime_i,
    input logic              vend_o,
    input logic              change_o,
    input logic [CRED_W-1:0] credit_q
);
    // R10
    change_needs_vend_chk: assert property (@(posedge clk) disable iff (rst)
        change_o |-> vend_o);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!nickel_i && !dime_i) |-> (!vend_o && !change_o));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!nickel_i && !dime_i) |=> (credit_q == $past(credit_q)));

    // R8
    clash_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && dime_i) |-> (!vend_o && !change_o));

    // R8
    clash_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && dime_i) |=> (credit_q == $past(credit_q)));

    // R4
    sale_clears_chk: assert property (@(posedge clk) disable iff (rst)
        vend_o |=> (credit_q == '0));

    // R2
    nickel_adds_chk: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && !dime_i && credit_q != CRED_W'(PRICE_UNITS - 1))
            |=> (credit_q == $past(credit_q) + CRED_W'(1)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> (!vend_o && !change_o));
endmodule

bind vend_ctrl vend_ctrl_chk #(.PRICE_UNITS(PRICE_UNITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .vend_o   (vend_o),
    .change_o (change_o),
    .credit_q (credit_q)
);

// File: tb/vend_ctrl_bench.sv
`timescale 1ns/1ps
module vend_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic vend_o, change_o;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    vend_ctrl u_vend_ctrl (
        .clk      (clk),
        .rst      (rst),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .vend_o   (vend_o),
        .change_o (change_o)
    );

    task automatic check(input string req, input logic ev, input logic ec);
        n_checks++;
        if (vend_o !== ev || change_o !== ec) begin
            n_fail++;
            $display("FAIL %s: vend/change = %b%b, expected %b%b", req, vend_o, change_o, ev, ec);
        end
    endtask

    // Drive one cycle of coin pulses, sample the Mealy outputs before the edge
    task automatic step(input logic n, input logic d, input logic ev, input logic ec, input string req);
        @(negedge clk);
        nickel_i = n;
        dime_i   = d;
        #1;
        check(req, ev, ec);
        @(posedge clk);
        #0.5;
        nickel_i = 1'b0;
        dime_i   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        nickel_i = 1'b1;
        #1;
        check("R1 outputs low in reset", 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        dime_i = 1'b1;
        nickel_i = 1'b0;
        #1;
        check("R1 outputs low in reset", 1'b0, 1'b0);
        @(posedge clk);
        #0.5;
        rst = 1'b0;
        dime_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        step(0, 1, 0, 0, "R1 credit zero after reset (R3)");
        step(0, 1, 1, 0, "R1 second dime vends (R5 R9)");
    endtask

    task automatic t_nickels();
        step(1, 0, 0, 0, "R2 nickel 0->5");
        step(1, 0, 0, 0, "R2 nickel 5->10");
        step(1, 0, 0, 0, "R2 nickel 10->15");
        step(1, 0, 1, 0, "R4 nickel at 15 vends (R9)");
        step(1, 0, 0, 0, "R4 credit cleared after sale");
        step(0, 1, 0, 0, "R3 dime 5->15");
        step(1, 0, 1, 0, "R4 nickel at 15 vends");
    endtask

    task automatic t_change();
        step(1, 0, 0, 0, "R2 nickel 0->5");
        step(0, 1, 0, 0, "R3 dime 5->15");
        step(0, 1, 1, 1, "R6 dime at 15 vends with change (R10)");
        step(0, 1, 0, 0, "R6 credit cleared after change");
        step(0, 1, 1, 0, "R5 dime at 10 vends, no change");
    endtask

    task automatic t_idle();
        step(1, 0, 0, 0, "R2 nickel 0->5");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R7 idle outputs low");
        step(1, 0, 0, 0, "R7 credit held, 5->10");
        step(0, 1, 1, 0, "R7 dime at held 10 vends");
    endtask

    task automatic t_clash();
        step(1, 1, 0, 0, "R8 clash at 0 quiet");
        step(0, 1, 0, 0, "R8 credit still 0 after clash");
        step(1, 0, 0, 0, "R2 nickel 10->15");
        step(1, 1, 0, 0, "R8 clash at 15 quiet");
        step(1, 1, 0, 0, "R8 clash at 15 quiet again");
        step(1, 0, 1, 0, "R8 credit held at 15, nickel vends");
    endtask

    task automatic t_midreset();
        step(1, 0, 0, 0, "R2 nickel 0->5");
        step(1, 0, 0, 0, "R2 nickel 5->10");
        do_reset();
        step(0, 1, 0, 0, "R1 reset clears credit of 10");
        step(0, 1, 1, 0, "R1 sale after reset needs 20");
    endtask

    initial begin
        t_reset_state();
        t_nickels();
        t_change();
        t_idle();
        t_clash();
        t_midreset();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule